// File: doc/BRIEF.md
# Interval Timer Port Interface

This block is the byte-wide host front end of a three-channel interval timer. A host reaches it through one request stream: each request names one of four ports. Ports 0 to 2 carry the data bytes of channels 0 to 2, and port 3 takes command bytes. The block decodes those commands and keeps the access mode, counting mode and number format of each channel. It splits 16-bit count loads and count reads into byte transfers, and it holds latched counts and latched status bytes until the host reads them. The counting itself lives in three counter channels outside this block. They receive load pulses, load values and their configuration from this block, and they return their live count, output pin and count-loaded flag.

Requests use a valid/ready handshake and are taken when `req_valid` and `req_ready` are both high. A write produces no response. A read produces exactly one response byte: `rsp_valid` rises in the cycle after the read is accepted and stays high, with `rsp_data` unchanged, until `rsp_ready` is seen high. While a response is waiting, `req_ready` is low, so the host can apply back-pressure without anything being lost.

A command byte is laid out as follows. Bits 7-4 hold the operation, bits 3-1 the counting mode (codes 000 to 101 select modes 0 to 5, and codes 11x are undefined) and bit 0 the number format (0 for binary, 1 for BCD). In the operation nibble, values 00xx, 01xx and 10xx address channels 0, 1 and 2, and the two low bits select the action: 00 latches the count, 01 gives low-byte access, 10 gives high-byte access and 11 gives low-then-high 16-bit access. Operation 1101 latches the counts of the channels chosen in bits 3..1, and operation 1110 latches their status. In both, bit 1 selects channel 0, bit 2 channel 1 and bit 3 channel 2.

Top module: `ivt_port_if`

## Requirements
- R1: An access-mode command (operation `cc01`, `cc10` or `cc11` for channel `cc`) stores the counting mode from bits 3-1 and the format from bit 0 for that channel. It drives them on `cnt_mode` and `cnt_bcd` and gives a one-cycle `cnt_cfg` pulse for that channel in the cycle after the command is accepted.
- R2: In low-byte access mode, a data write of byte d loads the value {8'h00, d}. In high-byte access mode it loads {d, 8'h00}. Each load is a one-cycle `cnt_load` pulse for that channel, with the value on `cnt_load_val`, in the cycle after the write is accepted.
- R3: In 16-bit access mode, the first data write gives no load pulse. The second write loads {second byte, first byte}.
- R4: A read of a channel with no latch pending returns bytes of the live count. Low-byte mode returns bits 7:0, and high-byte mode returns bits 15:8. 16-bit mode returns the low byte and then the high byte, alternating.
- R5: A count latch (operation `cc00`) samples the channel's count when the command is accepted. Reads return bytes of that held value, in the order of R4, until all bytes for the access mode have been read. After that, reads return the live count again.
- R6: While a latched count of a channel is not yet fully read, further access-mode and count-latch commands to that channel have no effect.
- R7: Operation 1101 latches the counts of exactly the channels whose select bits are set, and leaves the other channels reading live.
- R8: Operation 1110 latches a status byte for each selected channel. The byte holds the output pin in bit 7, the count-loaded flag in bit 6, the access mode in bits 5-4 (01 high byte only, 10 low byte only, 11 both), the counting mode in bits 3-1 and the format in bit 0. The next read of that channel returns this byte once.
- R9: When status and count are both latched for a channel, the status byte is read first, and the count bytes follow.
- R10: An access-mode command resets the write byte pointer and the read byte pointer of that channel to the low byte.
- R11: A read response appears one cycle after the read is accepted. It is held, with stable data, while `rsp_ready` is low, and `req_ready` stays low for as long as the response waits.
- R12: After reset, every channel is in 16-bit access mode with counting mode 0 and binary format. No latch is pending, no load or configuration pulse is driven, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Port: 0..2 channel data, 3 command |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Read response byte |
| cnt_load | output | NCH | Per-channel one-cycle load pulse |
| cnt_load_val | output | 16*NCH | Per-channel load value |
| cnt_cfg | output | NCH | Per-channel one-cycle configuration pulse |
| cnt_mode | output | 3*NCH | Per-channel counting mode |
| cnt_bcd | output | NCH | Per-channel BCD select |
| cnt_value | input | 16*NCH | Per-channel live count |
| cnt_out | input | NCH | Per-channel output pin state |
| cnt_loaded | input | NCH | Per-channel count-loaded flag |

## Verification
The assertions check the handshake rules on every cycle. They verify that a waiting response holds its data and blocks new requests, and that every response follows an accepted read. They also verify that every load pulse follows a data write to that same channel and that every configuration pulse follows a command write. Only the bench scenarios can show the byte-level behaviour. This covers byte ordering in each access mode, a latched value surviving changes of the live count, commands ignored while a latch is pending, the selective multi-channel latch, status-before-count ordering and the reset of the byte pointers.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_HI   = 2'b01,
    ACC_LO   = 2'b10,
    ACC_WORD = 2'b11
  } acc_e;

  localparam logic [3:0] OP_MULTI_CNT = 4'b1101;
  localparam logic [3:0] OP_MULTI_STS = 4'b1110;

  function automatic acc_e acc_from_cmd(input logic [1:0] rw);
    case (rw)
      2'b01:   return ACC_LO;
      2'b10:   return ACC_HI;
      2'b11:   return ACC_WORD;
      default: return ACC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ivt_cmd_decode.sv
module ivt_cmd_decode
  import ivt_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              wr_cmd,
  input  logic [BYTE_W-1:0] cmd_byte,
  output logic [NCH-1:0]    latch_cnt,
  output logic [NCH-1:0]    latch_sts,
  output logic [NCH-1:0]    set_acc,
  output acc_e              acc,
  output logic [MODE_W-1:0] mode,
  output logic              bcd
);
  logic [3:0]     op;
  logic [NCH-1:0] sel;

  assign op   = cmd_byte[7:4];
  assign sel  = cmd_byte[NCH:1];
  assign acc  = acc_from_cmd(op[1:0]);
  assign mode = cmd_byte[3:1];
  assign bcd  = cmd_byte[0];

  always_comb begin
    latch_cnt = '0;
    latch_sts = '0;
    set_acc   = '0;
    if (wr_cmd) begin
      if (op == OP_MULTI_CNT) begin
        latch_cnt = sel;
      end else if (op == OP_MULTI_STS) begin
        latch_sts = sel;
      end else begin
        for (int c = 0; c < NCH; c++) begin
          if (op[3:2] == 2'(c)) begin
            if (op[1:0] == 2'b00) latch_cnt[c] = 1'b1;
            else                  set_acc[c]   = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ivt_chan.sv
module ivt_chan
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_cnt,
  input  logic              latch_sts,
  input  logic              set_acc,
  input  acc_e              acc_in,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              bcd_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt_value,
  input  logic              cnt_out,
  input  logic              cnt_loaded,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              cfg,
  output logic [MODE_W-1:0] mode,
  output logic              bcd
);
  acc_e              acc_q;
  logic [MODE_W-1:0] mode_q;
  logic              bcd_q;
  logic              wptr_q, rptr_q;
  logic [BYTE_W-1:0] lo_hold_q;
  logic [CNT_W-1:0]  cnt_lat_q;
  logic              cnt_lat_v;
  logic [BYTE_W-1:0] sts_lat_q;
  logic              sts_lat_v;
  logic              load_q, cfg_q;
  logic [CNT_W-1:0]  load_val_q;
  logic [CNT_W-1:0]  src;
  logic [BYTE_W-1:0] sts_now;

  assign sts_now = {cnt_out, cnt_loaded, acc_q, mode_q, bcd_q};
  assign src     = cnt_lat_v ? cnt_lat_q : cnt_value;

  always_comb begin
    rd_byte = '0;
    if (sts_lat_v) begin
      rd_byte = sts_lat_q;
    end else begin
      case (acc_q)
        ACC_LO:   rd_byte = src[BYTE_W-1:0];
        ACC_HI:   rd_byte = src[CNT_W-1:BYTE_W];
        ACC_WORD: rd_byte = rptr_q ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
        default:  rd_byte = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= ACC_WORD;
      mode_q     <= '0;
      bcd_q      <= 1'b0;
      wptr_q     <= 1'b0;
      rptr_q     <= 1'b0;
      lo_hold_q  <= '0;
      cnt_lat_q  <= '0;
      cnt_lat_v  <= 1'b0;
      sts_lat_q  <= '0;
      sts_lat_v  <= 1'b0;
      load_q     <= 1'b0;
      load_val_q <= '0;
      cfg_q      <= 1'b0;
    end else begin
      load_q <= 1'b0;
      cfg_q  <= 1'b0;
      if (set_acc && !cnt_lat_v) begin
        acc_q  <= acc_in;
        mode_q <= mode_in;
        bcd_q  <= bcd_in;
        wptr_q <= 1'b0;
        rptr_q <= 1'b0;
        cfg_q  <= 1'b1;
      end
      if (latch_cnt && !cnt_lat_v) begin
        cnt_lat_q <= cnt_value;
        cnt_lat_v <= 1'b1;
      end
      if (latch_sts && !sts_lat_v) begin
        sts_lat_q <= sts_now;
        sts_lat_v <= 1'b1;
      end
      if (wr_en) begin
        case (acc_q)
          ACC_LO: begin
            load_val_q <= {{BYTE_W{1'b0}}, wdata};
            load_q     <= 1'b1;
          end
          ACC_HI: begin
            load_val_q <= {wdata, {BYTE_W{1'b0}}};
            load_q     <= 1'b1;
          end
          ACC_WORD: begin
            if (!wptr_q) begin
              lo_hold_q <= wdata;
              wptr_q    <= 1'b1;
            end else begin
              load_val_q <= {wdata, lo_hold_q};
              load_q     <= 1'b1;
              wptr_q     <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (rd_en) begin
        if (sts_lat_v) begin
          sts_lat_v <= 1'b0;
        end else if (acc_q == ACC_WORD) begin
          rptr_q <= ~rptr_q;
          if (rptr_q) cnt_lat_v <= 1'b0;
        end else begin
          cnt_lat_v <= 1'b0;
        end
      end
    end
  end

  assign load     = load_q;
  assign load_val = load_val_q;
  assign cfg      = cfg_q;
  assign mode     = mode_q;
  assign bcd      = bcd_q;
endmodule

// File: rtl/ivt_rsp.sv
module ivt_rsp
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [BYTE_W-1:0] rd_byte,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_byte;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ivt_port_if.sv
module ivt_port_if
  import ivt_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_we,
  input  logic [1:0]            req_addr,
  input  logic [7:0]            req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [7:0]            rsp_data,
  output logic [NCH-1:0]        cnt_load,
  output logic [NCH*16-1:0]     cnt_load_val,
  output logic [NCH-1:0]        cnt_cfg,
  output logic [NCH*3-1:0]      cnt_mode,
  output logic [NCH-1:0]        cnt_bcd,
  input  logic [NCH*16-1:0]     cnt_value,
  input  logic [NCH-1:0]        cnt_out,
  input  logic [NCH-1:0]        cnt_loaded
);
  localparam logic [1:0] CMD_ADDR = 2'd3;

  logic              fire, wr_cmd, rd_fire;
  logic [NCH-1:0]    latch_cnt, latch_sts, set_acc;
  acc_e              dec_acc;
  logic [MODE_W-1:0] dec_mode;
  logic              dec_bcd;
  logic [BYTE_W-1:0] ch_byte [NCH];
  logic [BYTE_W-1:0] rd_byte;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign wr_cmd    = fire && req_we && (req_addr == CMD_ADDR);
  assign rd_fire   = fire && !req_we;

  ivt_cmd_decode #(.NCH(NCH)) dec_i (
    .wr_cmd    (wr_cmd),
    .cmd_byte  (req_wdata),
    .latch_cnt (latch_cnt),
    .latch_sts (latch_sts),
    .set_acc   (set_acc),
    .acc       (dec_acc),
    .mode      (dec_mode),
    .bcd       (dec_bcd)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = fire && (req_addr == 2'(c));
    ivt_chan ch_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .latch_cnt  (latch_cnt[c]),
      .latch_sts  (latch_sts[c]),
      .set_acc    (set_acc[c]),
      .acc_in     (dec_acc),
      .mode_in    (dec_mode),
      .bcd_in     (dec_bcd),
      .wr_en      (hit && req_we),
      .rd_en      (hit && !req_we),
      .wdata      (req_wdata),
      .cnt_value  (cnt_value[c*CNT_W +: CNT_W]),
      .cnt_out    (cnt_out[c]),
      .cnt_loaded (cnt_loaded[c]),
      .rd_byte    (ch_byte[c]),
      .load       (cnt_load[c]),
      .load_val   (cnt_load_val[c*CNT_W +: CNT_W]),
      .cfg        (cnt_cfg[c]),
      .mode       (cnt_mode[c*MODE_W +: MODE_W]),
      .bcd        (cnt_bcd[c])
    );
  end

  always_comb begin
    rd_byte = '0;
    for (int c = 0; c < NCH; c++) begin
      if (req_addr == 2'(c)) rd_byte = ch_byte[c];
    end
  end

  ivt_rsp rsp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (rd_fire),
    .rd_byte   (rd_byte),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/ivt_port_chk.sv
module ivt_port_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           req_we,
  input logic [1:0]     req_addr,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [7:0]     rsp_data,
  input logic [NCH-1:0] cnt_load,
  input logic [NCH-1:0] cnt_cfg
);
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  p_ready_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  p_rsp_origin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready && !req_we));

  p_load_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cnt_load));

  p_cfg_origin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|cnt_cfg) |-> $past(req_valid && req_ready && req_we && req_addr == 2'd3));

  for (genvar c = 0; c < NCH; c++) begin : g_ld
    p_load_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_load[c] |-> $past(req_valid && req_ready && req_we && req_addr == 2'(c)));
  end
endmodule

bind ivt_port_if ivt_port_chk #(.NCH(NCH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_we    (req_we),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .cnt_load  (cnt_load),
  .cnt_cfg   (cnt_cfg)
);

// File: tb/ivt_port_if_tb.sv
module ivt_port_if_tb_top;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b1;
  logic [1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_data;
  logic [NCH-1:0] cnt_load, cnt_cfg, cnt_bcd;
  logic [NCH*16-1:0] cnt_load_val;
  logic [NCH*3-1:0] cnt_mode;
  logic [NCH*16-1:0] cv = '0;
  logic [NCH-1:0] out_r = 3'b101, ld_r = 3'b011;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [NCH-1:0] s_load, s_cfg;
  logic [NCH*16-1:0] s_val;

  always #10 clk = ~clk;

  ivt_port_if #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .cnt_cfg(cnt_cfg),
    .cnt_mode(cnt_mode), .cnt_bcd(cnt_bcd), .cnt_value(cv),
    .cnt_out(out_r), .cnt_loaded(ld_r)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_sts(input int c, input logic [1:0] acc,
                                         input logic [2:0] mode, input logic bcd);
    return {out_r[c], ld_r[c], acc, mode, bcd};
  endfunction

  function automatic logic [7:0] exp_byte(input logic [1:0] acc, input logic [15:0] v,
                                          input logic ptr);
    if (acc == 2'b10) return v[7:0];
    if (acc == 2'b01) return v[15:8];
    return ptr ? v[15:8] : v[7:0];
  endfunction

  function automatic logic [15:0] exp_load(input logic [1:0] acc, input logic [7:0] d0,
                                           input logic [7:0] d1);
    if (acc == 2'b10) return {8'h00, d0};
    if (acc == 2'b01) return {d0, 8'h00};
    return {d1, d0};
  endfunction

  // status access code -> command rw bits
  function automatic logic [1:0] rw_of(input logic [1:0] acc);
    if (acc == 2'b10) return 2'b01;
    if (acc == 2'b01) return 2'b10;
    return 2'b11;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    s_load = cnt_load; s_cfg = cnt_cfg; s_val = cnt_load_val;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_data : 8'hxx;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'd4242));
    cv[15:0] = 16'h2468; cv[31:16] = 16'h1357; cv[47:32] = 16'hABCD;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 req_ready", {15'd0, req_ready}, 16'd1);
    chk("R12 rsp_valid", {15'd0, rsp_valid}, 16'd0);
    chk("R12 cnt_load", {13'd0, cnt_load}, 16'd0);
    chk("R12 cnt_mode", {7'd0, cnt_mode}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    wr(2'd3, 8'hE2);
    rd(2'd0, b);
    chk("R12 R8 reset status ch0", {8'd0, b}, {8'd0, exp_sts(0, 2'b11, 3'd0, 1'b0)});

    // R1 / R2: low-byte and high-byte access
    wr(2'd3, 8'h14);
    chk("R1 cfg pulse ch0", {13'd0, s_cfg}, 16'd1);
    chk("R1 mode ch0", {13'd0, cnt_mode[2:0]}, 16'd2);
    wr(2'd0, 8'h5A);
    chk("R2 low-byte load", s_val[15:0], 16'h005A);
    chk("R2 load pulse ch0", {13'd0, s_load}, 16'd1);
    wr(2'd3, 8'h67);
    chk("R1 bcd ch1", {13'd0, cnt_bcd}, 16'd2);
    wr(2'd1, 8'hC3);
    chk("R2 high-byte load", s_val[31:16], 16'hC300);
    wr(2'd3, 8'hE4);
    rd(2'd1, b);
    chk("R8 status ch1", {8'd0, b}, {8'd0, exp_sts(1, 2'b01, 3'd3, 1'b1)});

    // R3 word write
    wr(2'd3, 8'hB2);
    wr(2'd2, 8'h34);
    chk("R3 no load after first byte", {13'd0, s_load}, 16'd0);
    wr(2'd2, 8'h12);
    chk("R3 word load", s_val[47:32], 16'h1234);

    // R4 live reads
    rd(2'd2, b); chk("R4 word lo", {8'd0, b}, 16'h00CD);
    rd(2'd2, b); chk("R4 word hi", {8'd0, b}, 16'h00AB);
    rd(2'd0, b); chk("R4 low-byte mode", {8'd0, b}, 16'h0068);
    rd(2'd1, b); chk("R4 high-byte mode", {8'd0, b}, 16'h0013);

    // R5 / R6 latch holding, ignored commands
    wr(2'd3, 8'h80);
    cv[47:32] = 16'h1111;
    rd(2'd2, b); chk("R5 latched lo", {8'd0, b}, 16'h00CD);
    wr(2'd3, 8'hB0);
    chk("R6 no cfg while latched", {13'd0, s_cfg}, 16'd0);
    chk("R6 mode kept", {13'd0, cnt_mode[8:6]}, 16'd1);
    wr(2'd3, 8'h80);
    rd(2'd2, b); chk("R5 latched hi", {8'd0, b}, 16'h00AB);
    rd(2'd2, b); chk("R5 live after release lo", {8'd0, b}, 16'h0011);
    rd(2'd2, b); chk("R6 second latch ignored hi", {8'd0, b}, 16'h0011);

    // R10 pointer reset
    wr(2'd2, 8'h77);
    wr(2'd3, 8'hB2);
    wr(2'd2, 8'h01);
    chk("R10 write ptr reset", {13'd0, s_load}, 16'd0);
    wr(2'd2, 8'h02);
    chk("R10 word load after reset", s_val[47:32], 16'h0201);
    cv[47:32] = 16'h4321;
    rd(2'd2, b);
    wr(2'd3, 8'hB2);
    rd(2'd2, b); chk("R10 read ptr reset", {8'd0, b}, 16'h0021);
    rd(2'd2, b);

    // R7 multi-channel count latch (channels 2 and 0)
    cv = {16'h0E0F, 16'h0C0D, 16'h0A0B};
    wr(2'd3, 8'hDA);
    cv = {16'h9999, 16'h8888, 16'h7777};
    rd(2'd1, b); chk("R7 unselected ch1 live", {8'd0, b}, 16'h0088);
    rd(2'd0, b); chk("R7 ch0 latched", {8'd0, b}, 16'h000B);
    rd(2'd2, b); chk("R7 ch2 latched lo", {8'd0, b}, 16'h000F);
    rd(2'd2, b); chk("R7 ch2 latched hi", {8'd0, b}, 16'h000E);
    rd(2'd0, b); chk("R7 ch0 live after read", {8'd0, b}, 16'h0077);

    // R9 status before count
    cv[47:32] = 16'h5566;
    wr(2'd3, 8'hD8);
    wr(2'd3, 8'hE8);
    cv[47:32] = 16'h0000;
    rd(2'd2, b); chk("R9 status first", {8'd0, b}, {8'd0, exp_sts(2, 2'b11, 3'd1, 1'b0)});
    rd(2'd2, b); chk("R9 count lo", {8'd0, b}, 16'h0066);
    rd(2'd2, b); chk("R9 count hi", {8'd0, b}, 16'h0055);

    // R11 back-pressure
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 2'd1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 rsp one cycle later", {15'd0, rsp_valid}, 16'd1);
    b = rsp_data;
    repeat (3) @(negedge clk);
    chk("R11 rsp held", {15'd0, rsp_valid}, 16'd1);
    chk("R11 data stable", {8'd0, rsp_data}, {8'd0, b});
    chk("R11 ready low while waiting", {15'd0, req_ready}, 16'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 rsp taken", {15'd0, rsp_valid}, 16'd0);

    // Random: program, load, latch, read
    for (int it = 0; it < 60; it++) begin
      int c;
      logic [1:0] acc;
      logic [2:0] mode;
      logic bcd;
      logic [7:0] d0, d1, g;
      logic [15:0] v;
      c = $urandom_range(0, NCH - 1);
      acc = 2'($urandom_range(1, 3));
      mode = 3'($urandom_range(0, 5));
      bcd = 1'($urandom_range(0, 1));
      d0 = 8'($urandom); d1 = 8'($urandom);
      wr(2'd3, {2'(c), rw_of(acc), mode, bcd});
      chk("R1 random mode", {13'd0, cnt_mode[c*3 +: 3]}, {13'd0, mode});
      wr(2'(c), d0);
      if (acc == 2'b11) wr(2'(c), d1);
      chk("R2 R3 random load", s_val[c*16 +: 16], exp_load(acc, d0, d1));
      v = 16'($urandom);
      cv[c*16 +: 16] = v;
      wr(2'd3, {2'(c), 6'b0});
      cv[c*16 +: 16] = ~v;
      rd(2'(c), g);
      chk("R5 random latched first", {8'd0, g}, {8'd0, exp_byte(acc, v, 1'b0)});
      if (acc == 2'b11) begin
        rd(2'(c), g);
        chk("R5 random latched second", {8'd0, g}, {8'd0, exp_byte(acc, v, 1'b1)});
      end
      rd(2'(c), g);
      chk("R4 random live", {8'd0, g}, {8'd0, exp_byte(acc, ~v, 1'b0)});
      if (acc == 2'b11) rd(2'(c), g);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule